// File: doc/BRIEF.md
# Shared Timer/Watchdog Prescaler Unit

This block holds an 8-bit up-counting timer and one divider counter that is lent to exactly one of two consumers. When the timer owns the divider, it acts as a prescaler: the timer advances once every 2^(n+1) source events. When the watchdog owns it, it acts as a postscaler: the watchdog counter advances once every 2^n watchdog ticks. The consumer without the divider counts undivided.

The timer source is either the instruction-cycle enable or an external pin. The pin passes through a two-stage synchroniser and an edge detector that counts either rising or falling edges. Writing the timer register loads a value and holds off counting for two cycles. A watchdog clear restarts the watchdog. Each clearing event empties the divider only when its consumer owns it. A change of owner always empties it, so a partial count never reaches the new owner. The watchdog raises a one-cycle timeout when its counter wraps, and only while it is enabled.

Top module: `tmr_wdt_share`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), tmr_value is 0x00, tmr_ovf and wdt_timeout are 0, and the divider and watchdog counters are empty.
- R2: With cfg_wdt_own=0 and ratio code n (0..7), the timer advances once per 2^(n+1) accepted source events, starting from an empty divider.
- R3: With cfg_wdt_own=1 and ratio code n, the watchdog counter advances once per 2^n wdt_tick pulses, and the timer advances on every accepted source event.
- R4: A tmr_wr pulse loads tmr_wr_data into the timer at the next edge and takes priority over an increment. While cfg_wdt_own=0 it also empties the divider. Source events in the two cycles after the write are discarded.
- R5: When the timer advances from 0xFF it wraps to 0x00, and tmr_ovf is 1 for exactly the cycle in which tmr_value first reads 0x00.
- R6: A wdt_clr pulse empties the watchdog counter. While cfg_wdt_own=1 it also empties the divider. No timeout is produced at the edge it is seen.
- R7: wdt_timeout pulses for one cycle when the watchdog counter (WDT_W bits, default 8) advances from all ones, and only if wdt_en is 1 in that cycle.
- R8: In a cycle where cfg_wdt_own differs from its value in the previous cycle, the divider is emptied and produces no divided tick.
- R9: With cfg_src_ext=0, every cycle with cyc_en=1 is a source event. With cfg_src_ext=1, a level change of ext_pin becomes a source event two edges after it is sampled, so the timer changes three edges after the pin moves. Rising edges count when cfg_fall_edge=0 and falling edges when it is 1.
- R10: A tmr_wr while cfg_wdt_own=1 leaves the watchdog divide phase untouched. A wdt_clr while cfg_wdt_own=0 leaves the timer divide phase untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, internal timer source |
| ext_pin | input | 1 | Asynchronous external count pin |
| cfg_src_ext | input | 1 | Timer source: 0 cycle enable, 1 external pin |
| cfg_fall_edge | input | 1 | Pin edge: 0 rising, 1 falling |
| cfg_wdt_own | input | 1 | Divider owner: 0 timer, 1 watchdog |
| cfg_ratio | input | 3 | Divide ratio code |
| tmr_wr | input | 1 | Timer register write strobe |
| tmr_wr_data | input | 8 | Timer write value |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_tick | input | 1 | Free-running watchdog tick pulse |
| wdt_en | input | 1 | Watchdog timeout enable |
| tmr_value | output | 8 | Current timer count |
| tmr_ovf | output | 1 | One-cycle wrap flag |
| wdt_timeout | output | 1 | One-cycle watchdog timeout |

## Verification
Two pairs of functions can land in one cycle. A timer write can meet a divided tick or a wrap from 0xFF, and a watchdog clear can meet the watchdog advance that would wrap its counter. The bench provokes both with random strobes laid over steady counting, and with owner changes that coincide with pending divider ticks. A cycle-level model built from the requirements predicts the result, with the write or the clear winning and no tick leaking through. All three outputs are compared with that model on every cycle.

// File: rtl/tws_pkg.sv
// Package: shared types and sizing for the shared timer/watchdog divider.
// Assumes: ratio field width fixes the divider width (2**RATIO_W bits).
package tws_pkg;
    typedef enum logic {
        OWN_TMR = 1'b0,
        OWN_WDT = 1'b1
    } owner_e;

    localparam int RATIO_W_DEF = 3;
    localparam int SYNC_DEF    = 2;
    localparam int INH_DEF     = 2;
endpackage

// File: rtl/tws_pin_sync.sv
// Module: tws_pin_sync
// Synchronises the external count pin through STAGES flops, then flags a
// rising or falling transition of the synchronised level for one cycle.
// Assumes: pin is asynchronous; events are combinational from flops only.
module tws_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // First synchroniser stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= pin;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Further synchroniser stages.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    // Transition flags of the synchronised level.
    always_comb begin
        rise = chain[STAGES-1] & ~last_q;
        fall = ~chain[STAGES-1] & last_q;
    end

    a_r9_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));
endmodule

// File: rtl/tws_divider.sv
// Module: tws_divider
// Shared divide counter. Counts inc pulses, is emptied by clr, and emits a
// tick when the low bits picked by the ratio all roll over together.
// Timer owner divides by 2^(n+1); watchdog owner by 2^n (n=0 passes through).
// Assumes: clr has priority over inc and suppresses the tick.
module tws_divider
    import tws_pkg::*;
#(
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  owner_e             owner,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               inc,
    input  logic               clr,
    output logic               tick
);
    localparam int PRE_W = 1 << RATIO_W;

    logic [PRE_W-1:0] cnt_q;
    logic [RATIO_W:0] span;
    logic [PRE_W:0]   one_hot;
    logic [PRE_W:0]   mask;
    logic             full;

    // Select how many low bits must be all ones for a divided tick.
    always_comb begin
        span    = {1'b0, ratio} + {{RATIO_W{1'b0}}, (owner == OWN_TMR)};
        one_hot = {{PRE_W{1'b0}}, 1'b1} << span;
        mask    = one_hot - {{PRE_W{1'b0}}, 1'b1};
        full    = ((cnt_q & mask[PRE_W-1:0]) == mask[PRE_W-1:0]);
        tick    = inc & ~clr & full;
    end

    // Divider counter: clear wins, else count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (inc)      cnt_q <= cnt_q + 1'b1;
    end

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));
    a_r2_tick_needs_inc: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (inc && !clr));
endmodule

// File: rtl/tws_timer.sv
// Module: tws_timer
// 8-bit timer register with load, increment, wrap flag and a post-write
// hold-off that discards source events for INH_CYC cycles.
// Assumes: inc is derived from evt_ok (directly or through the divider).
module tws_timer #(
    parameter int TMR_W   = 8,
    parameter int INH_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_evt,
    input  logic             inc,
    input  logic             wr,
    input  logic [TMR_W-1:0] wr_data,
    output logic             evt_ok,
    output logic [TMR_W-1:0] value,
    output logic             ovf
);
    localparam int IW = $clog2(INH_CYC + 1);

    logic [IW-1:0]    inh_q;
    logic [TMR_W-1:0] cnt_q;
    logic             ovf_q;

    // Source events pass only when no hold-off is pending.
    always_comb evt_ok = raw_evt & (inh_q == '0);

    // Hold-off counter armed by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)             inh_q <= '0;
        else if (wr)            inh_q <= IW'(INH_CYC);
        else if (inh_q != '0)   inh_q <= inh_q - 1'b1;
    end

    // Timer register: write wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (wr)  cnt_q <= wr_data;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    // Wrap flag for the cycle that shows the wrapped value.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ~wr & inc & (&cnt_q);
    end

    always_comb begin
        value = cnt_q;
        ovf   = ovf_q;
    end

    a_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt_q == $past(wr_data)));
    a_r4_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr) && !wr) |=> $stable(cnt_q));
    a_r5_ovf_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == '0));
endmodule

// File: rtl/tws_watchdog.sv
// Module: tws_watchdog
// Watchdog counter advanced by adv pulses, emptied by clr; pulses timeout
// for one cycle on wrap when enabled.
// Assumes: adv comes from the divider or the raw tick, chosen by the top.
module tws_watchdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    input  logic en,
    output logic timeout
);
    logic [WDT_W-1:0] cnt_q;
    logic             to_q;

    // Watchdog count: clear wins, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (adv)      cnt_q <= cnt_q + 1'b1;
    end

    // Registered timeout pulse on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) to_q <= 1'b0;
        else        to_q <= ~clr & adv & en & (&cnt_q);
    end

    always_comb timeout = to_q;

    a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        to_q |-> $past(en));
    a_r6_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !to_q);
    a_r7_wrapped_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        to_q |-> (cnt_q == '0));
endmodule

// File: rtl/tws_top.sv
// Module: tmr_wdt_share
// Top of the shared timer/watchdog divider unit. Picks the timer source,
// steers the single divider to its owner, routes clear events by owner,
// and empties the divider whenever ownership changes.
// Assumes: configuration inputs are synchronous to clk.
module tmr_wdt_share
    import tws_pkg::*;
#(
    parameter int RATIO_W = RATIO_W_DEF,
    parameter int TMR_W   = 8,
    parameter int WDT_W   = 8,
    parameter int SYNC_N  = SYNC_DEF,
    parameter int INH_CYC = INH_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_en,
    input  logic               ext_pin,
    input  logic               cfg_src_ext,
    input  logic               cfg_fall_edge,
    input  logic               cfg_wdt_own,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               tmr_wr,
    input  logic [TMR_W-1:0]   tmr_wr_data,
    input  logic               wdt_clr,
    input  logic               wdt_tick,
    input  logic               wdt_en,
    output logic [TMR_W-1:0]   tmr_value,
    output logic               tmr_ovf,
    output logic               wdt_timeout
);
    owner_e owner, owner_q;
    logic   ext_rise, ext_fall, raw_evt, evt_ok;
    logic   own_chg, div_inc, div_clr, div_tick;
    logic   tmr_inc, wdt_adv;

    tws_pin_sync #(.STAGES(SYNC_N)) u_sync (
        .clk (clk), .rst_n(rst_n), .pin(ext_pin),
        .rise(ext_rise), .fall(ext_fall)
    );

    // Remember last owner to detect a reassignment.
    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= OWN_TMR;
        else        owner_q <= owner;
    end

    // Source selection, divider steering and owner-dependent clears.
    always_comb begin
        owner   = owner_e'(cfg_wdt_own);
        raw_evt = cfg_src_ext ? (cfg_fall_edge ? ext_fall : ext_rise) : cyc_en;
        own_chg = (owner != owner_q);
        div_inc = (owner == OWN_WDT) ? wdt_tick : evt_ok;
        div_clr = own_chg
                | ((owner == OWN_TMR) & tmr_wr)
                | ((owner == OWN_WDT) & wdt_clr);
        tmr_inc = (owner == OWN_WDT) ? evt_ok : div_tick;
        wdt_adv = (owner == OWN_WDT) ? div_tick : wdt_tick;
    end

    tws_divider #(.RATIO_W(RATIO_W)) u_div (
        .clk  (clk), .rst_n(rst_n), .owner(owner), .ratio(cfg_ratio),
        .inc  (div_inc), .clr(div_clr), .tick(div_tick)
    );

    tws_timer #(.TMR_W(TMR_W), .INH_CYC(INH_CYC)) u_tmr (
        .clk    (clk), .rst_n(rst_n), .raw_evt(raw_evt), .inc(tmr_inc),
        .wr     (tmr_wr), .wr_data(tmr_wr_data), .evt_ok(evt_ok),
        .value  (tmr_value), .ovf(tmr_ovf)
    );

    tws_watchdog #(.WDT_W(WDT_W)) u_wdt (
        .clk(clk), .rst_n(rst_n), .adv(wdt_adv), .clr(wdt_clr),
        .en (wdt_en), .timeout(wdt_timeout)
    );

    a_r8_no_tick_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
        own_chg |-> !div_tick);
    a_r3_timer_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wdt_own && !tmr_wr && evt_ok && tmr_value != '1) |=> (tmr_value == $past(tmr_value) + 1'b1));
endmodule

// File: tb/tb_tmr_wdt_share.sv
module tb_tmr_wdt_share;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cyc_en, ext_pin, cfg_src_ext, cfg_fall_edge, cfg_wdt_own;
    logic [2:0] cfg_ratio;
    logic       tmr_wr;
    logic [7:0] tmr_wr_data;
    logic       wdt_clr, wdt_tick, wdt_en;
    logic [7:0] tmr_value;
    logic       tmr_ovf, wdt_timeout;

    int n_run  = 0;
    int n_fail = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    tmr_wdt_share dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .cfg_src_ext(cfg_src_ext), .cfg_fall_edge(cfg_fall_edge),
        .cfg_wdt_own(cfg_wdt_own), .cfg_ratio(cfg_ratio), .tmr_wr(tmr_wr),
        .tmr_wr_data(tmr_wr_data), .wdt_clr(wdt_clr), .wdt_tick(wdt_tick),
        .wdt_en(wdt_en), .tmr_value(tmr_value), .tmr_ovf(tmr_ovf),
        .wdt_timeout(wdt_timeout)
    );

    // Reference state, built from the requirements.
    logic       m_s1, m_s2, m_s3, m_own, m_ovf, m_to;
    logic [1:0] m_hold;
    logic [7:0] m_div, m_tmr, m_wdt;

    function automatic logic [7:0] low_mask(input logic own_wdt, input logic [2:0] n);
        int bits = own_wdt ? int'(n) : int'(n) + 1;
        return 8'((9'd1 << bits) - 9'd1);
    endfunction

    task automatic model_edge();
        logic ev, src, pclr, pinc, ptick, tinc, winc;
        logic [7:0] mk;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_own = 0; m_ovf = 0; m_to = 0;
            m_hold = 0; m_div = 0; m_tmr = 0; m_wdt = 0;
            return;
        end
        ev    = cfg_fall_edge ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
        src   = (cfg_src_ext ? ev : cyc_en) && (m_hold == 0);
        pclr  = (cfg_wdt_own != m_own) || (!cfg_wdt_own && tmr_wr) || (cfg_wdt_own && wdt_clr);
        pinc  = cfg_wdt_own ? wdt_tick : src;
        mk    = low_mask(cfg_wdt_own, cfg_ratio);
        ptick = pinc && !pclr && ((m_div & mk) == mk);
        tinc  = cfg_wdt_own ? src : ptick;
        winc  = cfg_wdt_own ? ptick : wdt_tick;
        m_ovf = !tmr_wr && tinc && (m_tmr == 8'hFF);
        m_to  = !wdt_clr && winc && wdt_en && (m_wdt == 8'hFF);
        m_div = pclr ? 8'd0 : (pinc ? m_div + 8'd1 : m_div);
        m_tmr = tmr_wr ? tmr_wr_data : (tinc ? m_tmr + 8'd1 : m_tmr);
        m_wdt = wdt_clr ? 8'd0 : (winc ? m_wdt + 8'd1 : m_wdt);
        m_hold = tmr_wr ? 2'd2 : (m_hold != 0 ? m_hold - 2'd1 : 2'd0);
        m_own = cfg_wdt_own;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    endtask

    task automatic chk(input string t, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // One clock: model follows the edge, outputs compared mid-cycle.
    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "tmr_value", int'(tmr_value), int'(m_tmr));
        chk(tag, "tmr_ovf", int'(tmr_ovf), int'(m_ovf));
        chk(tag, "wdt_timeout", int'(wdt_timeout), int'(m_to));
    endtask

    task automatic quiet();
        cyc_en = 0; tmr_wr = 0; wdt_clr = 0; wdt_tick = 0;
    endtask

    task automatic do_write(input logic [7:0] v);
        tmr_wr = 1; tmr_wr_data = v; cycle(); tmr_wr = 0;
    endtask

    task automatic rand_run(input int n, input int p_wr, input int p_clr,
                            input int p_own, input int p_pin);
        for (int i = 0; i < n; i++) begin
            cyc_en   = ($urandom % 100) < 60;
            wdt_tick = ($urandom % 100) < 70;
            tmr_wr   = ($urandom % 1000) < p_wr;
            tmr_wr_data = 8'($urandom);
            wdt_clr  = ($urandom % 1000) < p_clr;
            if (($urandom % 1000) < p_own) cfg_wdt_own = ~cfg_wdt_own;
            if (($urandom % 100) < p_pin) ext_pin = ~ext_pin;
            if (($urandom % 500) == 0) cfg_ratio = 3'($urandom);
            cycle();
        end
        quiet();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (tag %s) actual=hung expected=done", tag);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240613));
        rst_n = 0; quiet(); ext_pin = 0; cfg_src_ext = 0; cfg_fall_edge = 0;
        cfg_wdt_own = 0; cfg_ratio = 0; tmr_wr_data = 0; wdt_en = 1;
        repeat (3) cycle();
        rst_n = 1;
        // R1: reset values.
        tag = "R1";
        chk("R1", "tmr_value reset", int'(tmr_value), 0);
        chk("R1", "tmr_ovf reset", int'(tmr_ovf), 0);
        chk("R1", "wdt_timeout reset", int'(wdt_timeout), 0);

        // R2/R4 directed: 1:2, write, hold-off of two cycles, 8 events -> 4.
        tag = "R2";
        cyc_en = 1; do_write(8'h00);
        repeat (10) cycle();
        chk("R2", "tmr after 8 events at 1:2", int'(tmr_value), 4);
        cyc_en = 0;
        for (int r = 0; r < 8; r++) begin
            cfg_ratio = 3'(r); do_write(8'h00);
            rand_run(300 + 40 * r, 0, 0, 0, 0);
        end

        // R5 directed: wrap with watchdog owning the divider (timer direct).
        tag = "R5";
        cfg_wdt_own = 1; cycle();
        cyc_en = 1; do_write(8'hFF);
        cycle(); cycle(); cycle();
        chk("R5", "tmr wrapped", int'(tmr_value), 0);
        chk("R5", "ovf on wrap", int'(tmr_ovf), 1);
        cycle();
        chk("R5", "ovf one cycle", int'(tmr_ovf), 0);
        chk("R3", "direct count", int'(tmr_value), 1);
        cyc_en = 0;

        // R3: watchdog owns, each ratio.
        tag = "R3";
        for (int r = 0; r < 8; r++) begin
            cfg_ratio = 3'(r); rand_run(600, 0, 0, 0, 0);
        end

        // R4: random writes with the timer owning the divider.
        tag = "R4";
        cfg_wdt_own = 0; cfg_ratio = 1;
        rand_run(3000, 40, 0, 0, 0);

        // R6: watchdog clears against both owners.
        tag = "R6";
        cfg_ratio = 0; cfg_wdt_own = 1;
        rand_run(3000, 0, 3, 0, 0);
        cfg_wdt_own = 0;
        rand_run(2000, 0, 2, 0, 0);

        // R7: enable gating of timeouts.
        tag = "R7";
        for (int k = 0; k < 6; k++) begin
            wdt_en = k[0];
            wdt_tick = 1;
            repeat (300) cycle();
        end
        wdt_en = 1; quiet();

        // R8: frequent ownership changes.
        tag = "R8";
        cfg_ratio = 0;
        rand_run(4000, 5, 5, 60, 0);

        // R9 directed: pin edges with timer counting direct.
        tag = "R9";
        cfg_wdt_own = 1; cfg_src_ext = 1; cfg_fall_edge = 0; ext_pin = 0;
        cycle(); do_write(8'h05);
        repeat (4) cycle();
        ext_pin = 1; cycle(); cycle();
        chk("R9", "no count before sync", int'(tmr_value), 5);
        cycle();
        chk("R9", "rising counted", int'(tmr_value), 6);
        repeat (3) cycle();
        ext_pin = 0; repeat (4) cycle();
        chk("R9", "falling ignored", int'(tmr_value), 6);
        cfg_fall_edge = 1; repeat (2) cycle();
        ext_pin = 1; repeat (4) cycle();
        chk("R9", "rising ignored", int'(tmr_value), 6);
        ext_pin = 0; repeat (4) cycle();
        chk("R9", "falling counted", int'(tmr_value), 7);
        rand_run(2000, 10, 0, 0, 30);
        cfg_fall_edge = 0; cfg_wdt_own = 0;
        rand_run(2000, 10, 0, 0, 30);
        cfg_src_ext = 0;

        // R10: strobes aimed at the non-owner leave the divide phase alone.
        tag = "R10";
        cfg_wdt_own = 1; cfg_ratio = 3;
        rand_run(2500, 30, 0, 0, 0);
        cfg_wdt_own = 0; cfg_ratio = 2;
        rand_run(2500, 0, 30, 0, 0);

        // Mixed random traffic.
        tag = "R2";
        cfg_src_ext = 0;
        rand_run(6000, 10, 5, 5, 20);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule